// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from 64 sources and decides which one, if any, the processor should take next. Each source carries a 3-bit preemption level and a 2-bit subpriority, plus an enable. A level of zero removes the source from consideration. A latched request competes with the other eligible requests. The winner is offered to the processor only when its level is strictly above the level of the code that is running now. The block reports the winning vector number and its handler address. The address is a programmable table base plus the vector number times a 32-byte slot. In single-vector mode every vector is sent to the base address instead.

When the processor enters a handler it pulses an acknowledge. The running level is then raised to the winner's level, the interrupted level is pushed onto an 8-entry stack, and the winner's request flag is cleared. A return pulse pops the stack and restores the interrupted level. A handler running at the top level (7) is flagged so that the processor switches to a dedicated shadow register set. Lower levels use the primary set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no request is pending, the running level is 0, the table base is 0, `irq_req` and `shadow_sel` are 0, and `irq_addr` is 0.
- R2: A high bit of `irq_in` at a clock edge sets that source's request flag. The flag stays set until a software clear (`clr_valid` with `clr_idx`) or an accepted acknowledge of that vector. When a set and a clear hit the same flag in the same cycle, the set wins. A flag also stays set while its source is disabled.
- R3: A pending source takes part in selection only if its enable bit is 1 and its level is not 0.
- R4: Among eligible sources the winner has the highest level. A tie in level goes to the highest subpriority, and a remaining tie goes to the lowest vector number.
- R5: `irq_req` is 1 exactly when an eligible winner exists and its level is strictly greater than `run_lvl`. `irq_vec` and `irq_lvl` show the winner.
- R6: `irq_addr` equals base + 32 × `irq_vec` when `single_mode` is 0, and equals the base when `single_mode` is 1.
- R7: An `ack` while `irq_req` is 1 sets `run_lvl` to `irq_lvl` on the next edge. It also pushes the previous `run_lvl` and clears the winner's request flag.
- R8: A `ret` without an accepted `ack` in the same cycle pops the stack into `run_lvl`. A `ret` with an empty stack leaves `run_lvl` at 0. An accepted `ack` takes precedence over a simultaneous `ret`.
- R9: `shadow_sel` is 1 exactly while `run_lvl` is 7.
- R10: Writes of source configuration (`cfg_we`) and of the table base (`base_we`) take effect from the next clock edge.
- R11: An `ack` while `irq_req` is 0 changes neither `run_lvl` nor any request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Request inputs, one per source |
| clr_valid | input | 1 | Software clear strobe |
| clr_idx | input | 6 | Source whose flag is cleared |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Source being configured |
| cfg_lvl | input | 3 | Preemption level (0 disables) |
| cfg_sub | input | 2 | Subpriority |
| cfg_en | input | 1 | Source enable |
| base_we | input | 1 | Table base write strobe |
| base_in | input | 32 | New table base |
| single_mode | input | 1 | 1 sends all vectors to the base |
| ack | input | 1 | Handler entry acknowledge |
| ret | input | 1 | Handler return |
| irq_req | output | 1 | Preemption request to the processor |
| irq_vec | output | 6 | Winning vector number |
| irq_addr | output | 32 | Handler address of the winner |
| irq_lvl | output | 3 | Level of the winner |
| run_lvl | output | 3 | Level currently running |
| shadow_sel | output | 1 | Shadow register set select |

## Verification
Selection is tried with three pending sources at mixed levels and subpriorities, which separates the ordering by level from the ordering by subpriority. A fourth source that ties the leader in both level and subpriority shows whether the lower vector number breaks the tie. Nesting is driven through a level-3 handler interrupted by a level-7 one. This separates strict from non-strict preemption, shadow selection, restoration on return and an empty-stack return. Further patterns cover disabled and level-0 sources, a set and a clear in the same cycle, an acknowledge with no request, and an acknowledge together with a return. Each of these tells a correct priority or precedence rule apart from its plausible inverse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 3;
  localparam int SUB_W   = 2;
  localparam int LVL_TOP = 7;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [SUB_W-1:0] sub_t;
  typedef logic [LVL_W+SUB_W-1:0] rank_t;

  // Ordering key: level dominates, subpriority breaks level ties.
  function automatic rank_t rank_of(lvl_t lvl, sub_t sub);
    return {lvl, sub};
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       set_mask,
  input  logic [N_SRC-1:0]       clr_mask,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  lvl_t                   cfg_lvl,
  input  sub_t                   cfg_sub,
  input  logic                   cfg_en,
  output logic [N_SRC-1:0]       pend_q,
  output logic [N_SRC-1:0]       elig,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_q,
  output logic [N_SRC-1:0][SUB_W-1:0] sub_q
);
  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | set_mask;
    end
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[g]  <= 1'b0;
          lvl_q[g] <= '0;
          sub_q[g] <= '0;
        end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
          en_q[g]  <= cfg_en;
          lvl_q[g] <= cfg_lvl;
          sub_q[g] <= cfg_sub;
        end
      end
      assign elig[g] = pend_q[g] && en_q[g] && (lvl_q[g] != '0);
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            elig,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  input  logic [N_SRC-1:0][SUB_W-1:0] sub,
  output logic                        win_vld,
  output logic [IDX_W-1:0]            win_idx,
  output lvl_t                        win_lvl
);
  rank_t best;

  // Ascending scan with a strict compare keeps the lowest index on a full tie.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    best    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!win_vld || (rank_of(lvl[i], sub[i]) > best))) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
        best    = rank_of(lvl[i], sub[i]);
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  lvl_t             push_lvl,
  input  logic             pop,
  output lvl_t             top_lvl,
  output logic [CNT_W-1:0] depth
);
  lvl_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign wr_ptr  = PTR_W'(depth);
  assign rd_ptr  = PTR_W'(depth - CNT_W'(1));
  assign top_lvl = (depth == '0) ? lvl_t'(0) : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && (depth != CNT_W'(DEPTH))) begin
      depth <= depth + CNT_W'(1);
    end else if (pop && (depth != '0)) begin
      depth <= depth - CNT_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[g] <= '0;
        end else if (push && (depth != CNT_W'(DEPTH)) && (wr_ptr == PTR_W'(g))) begin
          mem[g] <= push_lvl;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC      = 64,
  parameter int ADDR_W     = 32,
  parameter int SLOT_SHIFT = 5,
  parameter int STK_DEPTH  = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_lvl,
  input  logic [1:0]        cfg_sub,
  input  logic              cfg_en,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              single_mode,
  input  logic              ack,
  input  logic              ret,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_vec,
  output logic [ADDR_W-1:0] irq_addr,
  output logic [2:0]        irq_lvl,
  output logic [2:0]        run_lvl,
  output logic              shadow_sel
);
  // Named internal events, also seen by the bound checker.
  logic                        win_vld;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl;
  logic                        take;
  logic                        give_back;
  logic [N_SRC-1:0]            pend_w;
  logic [N_SRC-1:0]            elig_w;
  logic [N_SRC-1:0]            clr_mask;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_w;
  logic [N_SRC-1:0][SUB_W-1:0] sub_w;
  lvl_t                        stk_top;
  logic [CNT_W-1:0]            stk_depth;
  logic [ADDR_W-1:0]           vec_base_q;
  lvl_t                        run_q;

  function automatic logic [ADDR_W-1:0] handler_addr(
    input logic [ADDR_W-1:0] base, input logic [IDX_W-1:0] vec, input logic single);
    if (single) return base;
    return base + (ADDR_W'(vec) << SLOT_SHIFT);
  endfunction

  function automatic logic [N_SRC-1:0] one_hot(input logic [IDX_W-1:0] idx);
    return N_SRC'(1) << idx;
  endfunction

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_mask(irq_in), .clr_mask(clr_mask),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .cfg_sub(cfg_sub), .cfg_en(cfg_en),
    .pend_q(pend_w), .elig(elig_w), .lvl_q(lvl_w), .sub_q(sub_w)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .elig(elig_w), .lvl(lvl_w), .sub(sub_w),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign irq_req   = win_vld && (win_lvl > run_q);
  assign take      = ack && irq_req;
  assign give_back = ret && !take && (stk_depth != '0);
  assign clr_mask  = (clr_valid ? one_hot(clr_idx) : '0) |
                     (take      ? one_hot(win_idx) : '0);

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_lvl(run_q), .pop(give_back),
    .top_lvl(stk_top), .depth(stk_depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      vec_base_q <= '0;
    end else begin
      if (take)           run_q <= win_lvl;
      else if (give_back) run_q <= stk_top;
      if (base_we)        vec_base_q <= base_in;
    end
  end

  assign irq_vec    = win_idx;
  assign irq_lvl    = win_lvl;
  assign irq_addr   = handler_addr(vec_base_q, win_idx, single_mode);
  assign run_lvl    = run_q;
  assign shadow_sel = (run_q == lvl_t'(LVL_TOP));
endmodule

module irq_prio_ctrl_chk #(
  parameter int N_SRC     = 64,
  parameter int STK_DEPTH = 8,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_in,
  input logic [N_SRC-1:0] pend_w,
  input logic             ack,
  input logic             ret,
  input logic             irq_req,
  input logic [2:0]       irq_lvl,
  input logic [2:0]       run_lvl,
  input logic             shadow_sel,
  input logic             take,
  input logic [CNT_W-1:0] stk_depth
);
  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> ((pend_w & $past(irq_in)) == $past(irq_in)));

  a_r5_req_above_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > run_lvl));

  a_r7_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (run_lvl == $past(irq_lvl)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (stk_depth != CNT_W'(STK_DEPTH)));

  a_r8_ret_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take && (stk_depth != '0)) |=> (run_lvl < $past(run_lvl)));

  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_depth == '0) |-> (run_lvl == 3'd0));

  a_r9_top_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (irq_lvl == 3'd7)) |=> shadow_sel);

  a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !ret) |=> $stable(run_lvl));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .STK_DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pend_w(pend_w),
  .ack(ack), .ret(ret), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .run_lvl(run_lvl), .shadow_sel(shadow_sel), .take(take),
  .stk_depth(stk_depth)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        clr_valid = 1'b0;
  logic [5:0]  clr_idx = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [2:0]  cfg_lvl = '0;
  logic [1:0]  cfg_sub = '0;
  logic        cfg_en = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_in = '0;
  logic        single_mode = 1'b0;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        irq_req;
  logic [5:0]  irq_vec;
  logic [31:0] irq_addr;
  logic [2:0]  irq_lvl;
  logic [2:0]  run_lvl;
  logic        shadow_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_valid(clr_valid), .clr_idx(clr_idx),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .cfg_sub(cfg_sub), .cfg_en(cfg_en),
    .base_we(base_we), .base_in(base_in), .single_mode(single_mode),
    .ack(ack), .ret(ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_addr(irq_addr),
    .irq_lvl(irq_lvl), .run_lvl(run_lvl), .shadow_sel(shadow_sel)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int idx, input int lvl, input int sub, input bit en);
    cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_lvl = 3'(lvl); cfg_sub = 2'(sub); cfg_en = en;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic raise(input logic [63:0] mask);
    irq_in = mask;
    step();
    irq_in = '0;
  endtask

  task automatic swclr(input int idx);
    clr_valid = 1'b1; clr_idx = 6'(idx);
    step();
    clr_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 run_lvl", 32'(run_lvl), 0);
    chk("R1 shadow_sel", 32'(shadow_sel), 0);
    chk("R1 irq_addr", irq_addr, 0);
  endtask

  task automatic t_enable();
    set_cfg(5, 3, 0, 1'b0);
    raise(64'd1 << 5);
    chk("R3 disabled source ignored", 32'(irq_req), 0);
    set_cfg(6, 0, 1, 1'b1);
    raise(64'd1 << 6);
    chk("R3 level-0 source ignored", 32'(irq_req), 0);
    set_cfg(5, 3, 0, 1'b1);
    chk("R2 flag kept while disabled, req", 32'(irq_req), 1);
    chk("R10 cfg applied, vec", 32'(irq_vec), 5);
    swclr(5);
    chk("R2 software clear", 32'(irq_req), 0);
    swclr(6);
    irq_in = 64'd1 << 5; clr_valid = 1'b1; clr_idx = 6'd5;
    step();
    irq_in = '0; clr_valid = 1'b0;
    chk("R2 set beats clear", 32'(irq_req), 1);
    chk("R2 set beats clear, vec", 32'(irq_vec), 5);
    swclr(5);
    chk("R2 cleared again", 32'(irq_req), 0);
  endtask

  task automatic t_order();
    set_cfg(10, 3, 1, 1'b1);
    set_cfg(20, 3, 2, 1'b1);
    set_cfg(30, 2, 3, 1'b1);
    raise((64'd1 << 10) | (64'd1 << 20) | (64'd1 << 30));
    chk("R4 level then subpriority, vec", 32'(irq_vec), 20);
    chk("R5 winner level", 32'(irq_lvl), 3);
    chk("R5 request above idle", 32'(irq_req), 1);
    set_cfg(8, 3, 2, 1'b1);
    raise(64'd1 << 8);
    chk("R4 full tie goes to lower vector", 32'(irq_vec), 8);
  endtask

  task automatic t_addr();
    base_we = 1'b1; base_in = 32'h0000_1000;
    step();
    base_we = 1'b0;
    chk("R6 R10 multi-vector address", irq_addr, 32'h0000_1100);
    single_mode = 1'b1;
    #1;
    chk("R6 single-vector address", irq_addr, 32'h0000_1000);
    single_mode = 1'b0;
    #1;
  endtask

  task automatic t_nest();
    pulse_ack();
    chk("R7 run level raised", 32'(run_lvl), 3);
    chk("R9 primary set below top", 32'(shadow_sel), 0);
    chk("R5 equal level does not preempt", 32'(irq_req), 0);
    chk("R7 taken flag cleared, next vec", 32'(irq_vec), 20);
    set_cfg(40, 7, 0, 1'b1);
    raise(64'd1 << 40);
    chk("R5 higher level preempts", 32'(irq_req), 1);
    chk("R6 address of vector 40", irq_addr, 32'h0000_1500);
    pulse_ack();
    chk("R7 nested run level", 32'(run_lvl), 7);
    chk("R9 shadow set at top", 32'(shadow_sel), 1);
    pulse_ack();
    chk("R11 ack without request", 32'(run_lvl), 7);
    chk("R11 flags untouched, vec", 32'(irq_vec), 20);
    pulse_ret();
    chk("R8 return restores level", 32'(run_lvl), 3);
    chk("R9 shadow released", 32'(shadow_sel), 0);
    pulse_ret();
    chk("R8 return to idle", 32'(run_lvl), 0);
    chk("R5 pending request reappears", 32'(irq_req), 1);
    pulse_ret();
    chk("R8 return on empty stack", 32'(run_lvl), 0);
    ack = 1'b1; ret = 1'b1;
    step();
    ack = 1'b0; ret = 1'b0;
    chk("R8 ack beats simultaneous ret", 32'(run_lvl), 3);
    pulse_ret();
    chk("R8 pop after combined cycle", 32'(run_lvl), 0);
    chk("R4 remaining order, vec", 32'(irq_vec), 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_enable();
    t_order();
    t_addr();
    t_nest();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule